// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of an 8-bit asynchronous parallel flash bus. It accepts a single request at a time from a valid/ready command port. A request carries an operation code, a byte address and a data byte. The block converts the request into the ordered train of write cycles that the flash needs to unlock and start a byte program, a sector erase or a full-array erase. Chip enable, write enable and output enable are all active low. Each write cycle has a setup phase, a pulse phase and a hold phase, and the length of each phase is a parameter counted in clocks.

When the last command write ends, the block does not wait a fixed time. It reads the target location and watches bit 7 of the data bus until that bit shows the operation has finished. A read can land exactly when the flash finishes, and that read can look like a failure. To guard against this, running out of the poll budget does not cause an immediate error. The block reads the location twice more and flags an error only if one of those confirming reads still fails. The result comes back as a one-cycle done pulse together with an error flag.

Top module: `flash_seq`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle, and a request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. From the next cycle `req_ready_o` stays low until the done pulse has ended.
- R2: Every write pulse holds `fl_we_no` low for exactly PULSE_CYC clocks. Address and data stay constant while it is low.
- R3: Operation code 0 (program) produces four writes as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (request address, request data).
- R4: Operation code 1 (sector erase) produces six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (request address, 30h).
- R5: Operation code 2 (chip erase) produces the same first five writes as R4, then (5555h, 10h).
- R6: Status reads start only after the final write has ended, and each one reads the request address. `fl_dq_oe_o` is low for at least one clock before `fl_oe_no` falls and stays low while `fl_oe_no` is low. `fl_we_no` and `fl_oe_no` are never low together.
- R7: A status read counts as passing when bit 7 equals bit 7 of the request data (program), or when bit 7 is 1 (either erase). The first passing read ends the operation with done and no error.
- R8: If MAX_POLLS reads in a row fail, exactly two more reads are made. Done is reported without error when both pass, and with error otherwise, so a run has at most MAX_POLLS+2 reads.
- R9: `done_o` is high for exactly one cycle. `err_o` is high only together with `done_o`. While `done_o` is high and afterwards until the next request, chip enable, write enable and output enable are all high.
- R10: Operation code 3 is reserved. It is accepted and answered with done and error set, with no bus cycle at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr_i | input | AW | Byte address (program target or address inside the sector) |
| req_data_i | input | 8 | Byte to program |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_addr_o | output | AW | Flash address |
| fl_dq_o | output | 8 | Data driven to the flash |
| fl_dq_oe_o | output | 1 | Host data driver enable |
| fl_dq_i | input | 8 | Data read from the flash |

## Verification
A wrong step index or a wrong operation code shows up on the very first affected write pulse as an address/data pair out of the expected sequence, or as too many or too few write pulses before the first status read. A wrong poll count or a wrong confirm state shows only at the end of the run, as a changed number of status reads or an error flag of the wrong value. The bench therefore sweeps the number of initially busy reads across the poll budget boundary for every operation code. A timing-phase fault appears within one bus cycle, either as a write pulse of the wrong length or as output enable overlapping the host data driver.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_HOLD} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_POLL, ST_DONE} seq_e;

  localparam logic [14:0] UNLK_ADDR_A = 15'h5555;
  localparam logic [14:0] UNLK_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam int unsigned PROG_STEPS  = 4;
  localparam int unsigned ERASE_STEPS = 6;
endpackage

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          last_o
);
  logic [AW-1:0] addr_a, addr_b;
  logic          is_prog;

  assign addr_a  = AW'(UNLK_ADDR_A);
  assign addr_b  = AW'(UNLK_ADDR_B);
  assign is_prog = (op_i == OP_PROG);

  always_comb begin
    addr_o = addr_a;
    data_o = UNLK_DATA_A;
    unique case (step_i)
      3'd0: begin addr_o = addr_a; data_o = UNLK_DATA_A; end
      3'd1: begin addr_o = addr_b; data_o = UNLK_DATA_B; end
      3'd2: begin addr_o = addr_a; data_o = is_prog ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        addr_o = is_prog ? addr_i : addr_a;
        data_o = is_prog ? data_i : UNLK_DATA_A;
      end
      3'd4: begin addr_o = addr_b; data_o = UNLK_DATA_B; end
      3'd5: begin
        addr_o = (op_i == OP_SECT) ? addr_i : addr_a;
        data_o = (op_i == OP_SECT) ? CMD_SECT : CMD_CHIP;
      end
      default: begin addr_o = addr_a; data_o = UNLK_DATA_A; end
    endcase
  end

  assign last_o = is_prog ? (step_i == 3'(PROG_STEPS - 1)) : (step_i == 3'(ERASE_STEPS - 1));
endmodule

// File: rtl/flash_bus_timer.sv
module flash_bus_timer
  import flash_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned RD_CYC    = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   go_i,
  input  logic   wr_i,
  output phase_e phase_o,
  output logic   cyc_end_o,
  output logic   sample_o
);
  localparam int unsigned MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_CD = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int unsigned MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CW = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] act_len;

  assign act_len = wr_i ? CW'(PULSE_CYC - 1) : CW'(RD_CYC - 1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (go_i) begin
        phase_d = PH_SETUP;
        cnt_d   = CW'(SETUP_CYC - 1);
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACT;
          cnt_d   = act_len;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_ACT: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = go_i ? PH_SETUP : PH_IDLE;
          cnt_d   = CW'(SETUP_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o   = phase_q;
  assign cyc_end_o = (phase_q == PH_HOLD) && (cnt_q == '0);
  assign sample_o  = (phase_q == PH_ACT) && (cnt_q == '0) && !wr_i;
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sample_i,
  input  logic pass_i,
  output logic fin_o,
  output logic ok_o
);
  localparam int unsigned PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0] polls_q;
  logic          confirm_q;
  logic          conf_idx_q;
  logic          conf_bad_q;

  // confirm mode: two extra reads, both must pass
  assign fin_o = sample_i && (confirm_q ? conf_idx_q : pass_i);
  assign ok_o  = confirm_q ? (!conf_bad_q && pass_i) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      polls_q    <= '0;
      confirm_q  <= 1'b0;
      conf_idx_q <= 1'b0;
      conf_bad_q <= 1'b0;
    end else if (clr_i) begin
      polls_q    <= '0;
      confirm_q  <= 1'b0;
      conf_idx_q <= 1'b0;
      conf_bad_q <= 1'b0;
    end else if (sample_i) begin
      if (confirm_q) begin
        conf_idx_q <= 1'b1;
        conf_bad_q <= conf_bad_q | !pass_i;
      end else if (!pass_i) begin
        polls_q <= polls_q + 1'b1;
        if (polls_q == PW'(MAX_POLLS - 1)) confirm_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW        = 17,  // at least 15
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [7:0]    req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i
);
  seq_e          state_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    step_q;
  logic          finishing_q;
  logic          err_q;

  logic          accept, wr, go, pass;
  logic          cyc_end, sample, fin, ok, last;
  phase_e        phase;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          unused_dq;

  assign unused_dq = ^fl_dq_i[6:0];

  assign accept = req_valid_i && req_ready_o;
  assign wr     = (state_q == ST_WRITE);
  assign go     = wr || ((state_q == ST_POLL) && !finishing_q);
  assign pass   = (op_q == OP_PROG) ? (fl_dq_i[7] == data_q[7]) : fl_dq_i[7];

  flash_cmd_gen #(.AW(AW)) u_cmd (
    .op_i   (op_q),
    .step_i (step_q),
    .addr_i (addr_q),
    .data_i (data_q),
    .addr_o (cmd_addr),
    .data_o (cmd_data),
    .last_o (last)
  );

  flash_bus_timer #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RD_CYC    (RD_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .wr_i      (wr),
    .phase_o   (phase),
    .cyc_end_o (cyc_end),
    .sample_o  (sample)
  );

  flash_poll_eval #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .sample_i (sample),
    .pass_i   (pass),
    .fin_o    (fin),
    .ok_o     (ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      finishing_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q        <= op_e'(req_op_i);
          addr_q      <= req_addr_i;
          data_q      <= req_data_i;
          step_q      <= '0;
          finishing_q <= 1'b0;
          err_q       <= (op_e'(req_op_i) == OP_RSVD);
          state_q     <= (op_e'(req_op_i) == OP_RSVD) ? ST_DONE : ST_WRITE;
        end
        ST_WRITE: if (cyc_end) begin
          if (last) state_q <= ST_POLL;
          else      step_q  <= step_q + 1'b1;
        end
        ST_POLL: begin
          if (fin) begin
            finishing_q <= 1'b1;
            err_q       <= !ok;
          end
          if (cyc_end && finishing_q) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = done_o && err_q;

  assign fl_ce_no   = (phase == PH_IDLE);
  assign fl_we_no   = !((phase == PH_ACT) && wr);
  assign fl_oe_no   = !((phase == PH_ACT) && !wr);
  assign fl_dq_oe_o = (phase != PH_IDLE) && wr;
  assign fl_addr_o  = wr ? cmd_addr : addr_q;
  assign fl_dq_o    = cmd_data;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int unsigned AW        = 17,
  parameter int unsigned PULSE_CYC = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          done_o,
  input logic          err_o,
  input logic          fl_ce_no,
  input logic          fl_we_no,
  input logic          fl_oe_no,
  input logic [AW-1:0] fl_addr_o,
  input logic [7:0]    fl_dq_o,
  input logic          fl_dq_oe_o
);
  int unsigned we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        we_low_cnt <= 0;
    else if (!fl_we_no) we_low_cnt <= we_low_cnt + 1;
    else                we_low_cnt <= 0;
  end

  p_ready_bus_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (fl_ce_no && fl_we_no && fl_oe_no));

  p_we_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (we_low_cnt == PULSE_CYC));

  p_we_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o);

  p_release_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_oe_no) |-> $past(!fl_dq_oe_o));

  p_we_oe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_done_bus_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fl_ce_no && fl_we_no && fl_oe_no));
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .fl_ce_no    (fl_ce_no),
  .fl_we_no    (fl_we_no),
  .fl_oe_no    (fl_oe_no),
  .fl_addr_o   (fl_addr_o),
  .fl_dq_o     (fl_dq_o),
  .fl_dq_oe_o  (fl_dq_oe_o)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  localparam int AW = 17;
  localparam int SETUP_CYC = 1;
  localparam int PULSE_CYC = 2;
  localparam int HOLD_CYC = 1;
  localparam int RD_CYC = 2;
  localparam int MAX_POLLS = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [7:0]    req_data_i = '0;
  logic          done_o, err_o;
  logic          fl_ce_no, fl_we_no, fl_oe_no, fl_dq_oe_o;
  logic [AW-1:0] fl_addr_o;
  logic [7:0]    fl_dq_o, fl_dq_i;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // flash model state
  int            busy = 0;
  logic [7:0]    pass_v = 8'hFF, fail_v = 8'h00;
  int            nwr = 0, nrd = 0, nce = 0, we_bad = 0, cont_bad = 0, we_run = 0;
  logic [AW-1:0] wa [8];
  logic [7:0]    wd [8];
  logic [AW-1:0] rd_addr = '0;

  always #2 clk_i = ~clk_i;

  flash_seq #(
    .AW(AW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC), .MAX_POLLS(MAX_POLLS)
  ) u_flash_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i, .req_data_i,
    .done_o, .err_o, .fl_ce_no, .fl_we_no, .fl_oe_no, .fl_addr_o, .fl_dq_o,
    .fl_dq_oe_o, .fl_dq_i
  );

  assign fl_dq_i = (nrd < busy) ? fail_v : pass_v;

  always @(posedge fl_we_no) if (rst_ni) begin
    if (nwr < 8) begin wa[nwr] = fl_addr_o; wd[nwr] = fl_dq_o; end
    nwr++;
  end
  always @(posedge fl_oe_no) if (rst_ni) begin nrd++; rd_addr = fl_addr_o; end
  always @(negedge fl_ce_no) if (rst_ni) nce++;

  always @(negedge clk_i) if (rst_ni) begin
    if (!fl_we_no) we_run++;
    else if (we_run != 0) begin
      if (we_run != PULSE_CYC) we_bad++;
      we_run = 0;
    end
    if (!fl_oe_no && (fl_dq_oe_o || !fl_we_no)) cont_bad++;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW+7:0] exp_wr(input int op, input int i,
                                          input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ua, ub;
    ua = AW'(17'h05555);
    ub = AW'(17'h02AAA);
    case (i)
      0: return {ua, 8'hAA};
      1: return {ub, 8'h55};
      2: return {ua, (op == 0) ? 8'hA0 : 8'h80};
      3: return (op == 0) ? {a, d} : {ua, 8'hAA};
      4: return {ub, 8'h55};
      default: return (op == 1) ? {a, 8'h30} : {ua, 8'h10};
    endcase
  endfunction

  task automatic run(input int op, input logic [AW-1:0] a, input logic [7:0] d, input int b);
    int n_exp_wr, n_exp_rd, wait_cyc;
    bit exp_err, got_done, got_err;
    busy = b;
    if (op == 0) begin pass_v = d; fail_v = d ^ 8'h80; end
    else begin pass_v = 8'hFF; fail_v = 8'h00; end
    nwr = 0; nrd = 0; nce = 0; we_bad = 0; cont_bad = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_addr_i = a; req_data_i = d;
    chk(req_ready_o == 1'b1, "R1 ready while idle", int'(req_ready_o), 1);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = 2'd3;
    chk(req_ready_o == 1'b0, "R1 ready low after accept", int'(req_ready_o), 0);
    wait_cyc = 0;
    while (!done_o && wait_cyc < 2000) begin @(negedge clk_i); wait_cyc++; end
    got_done = done_o;
    got_err = err_o;
    chk(got_done, "R9 done seen", int'(got_done), 1);
    @(negedge clk_i);
    chk(!done_o && req_ready_o && fl_ce_no, "R9 single done pulse then idle",
        {done_o, req_ready_o, fl_ce_no}, 3'b011);

    if (op == 3) begin
      chk(got_err, "R10 reserved op error", int'(got_err), 1);
      chk(nce == 0 && nwr == 0 && nrd == 0, "R10 no bus activity", nce + nwr + nrd, 0);
      return;
    end
    n_exp_wr = (op == 0) ? 4 : 6;
    n_exp_rd = (b < MAX_POLLS) ? b + 1 : MAX_POLLS + 2;
    exp_err  = (b > MAX_POLLS);
    chk(nwr == n_exp_wr, (op == 0) ? "R3 write count" : (op == 1) ? "R4 write count" : "R5 write count",
        nwr, n_exp_wr);
    for (int i = 0; i < n_exp_wr && i < 8; i++)
      chk({wa[i], wd[i]} == exp_wr(op, i, a, d),
          (op == 0) ? "R3 write pair" : (op == 1) ? "R4 write pair" : "R5 write pair",
          int'({wa[i], wd[i]}), int'(exp_wr(op, i, a, d)));
    chk(nrd == n_exp_rd, (b < MAX_POLLS) ? "R7 read count" : "R8 read count", nrd, n_exp_rd);
    chk(got_err == exp_err, (b < MAX_POLLS) ? "R7 error flag" : "R8 error flag",
        int'(got_err), int'(exp_err));
    chk(rd_addr == a, "R6 status read address", int'(rd_addr), int'(a));
    chk(cont_bad == 0, "R6 oe overlaps driver or we", cont_bad, 0);
    chk(we_bad == 0, "R2 write pulse width", we_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !done_o && !err_o, "R1 reset ready, no done",
        {req_ready_o, done_o, err_o}, 3'b100);
    chk(fl_ce_no && fl_we_no && fl_oe_no && !fl_dq_oe_o, "R9 reset bus idle",
        {fl_ce_no, fl_we_no, fl_oe_no, fl_dq_oe_o}, 4'b1110);
    for (int op = 0; op < 3; op++)
      for (int b = 0; b <= MAX_POLLS + 2; b++) begin
        run(op, 17'h1ABCD, 8'h5A, b);
        run(op, 17'h00123, 8'hC3, b);
      end
    run(3, 17'h0F0F0, 8'h11, 0);
    run(0, 17'h1FFFF, 8'h80, 0);
    summary();
    $finish;
  end
endmodule